// File: doc/BRIEF.md
# Event Frame Embedded-Line Builder and 2-Bit Pixel Packer

This block produces the byte stream for one raw event frame whose pixels carry 2-bit event codes. A frame starts with a strobe. The block then sends an embedded-data line, followed by the frame's pixels, packed four to a byte. The embedded line opens with a fixed 16-byte header. The header holds its own size, a data-type constant, a running frame number and the frame's timestamp. The rest of the line repeats the timestamp, byte by byte, until the programmed line length is reached.

The timestamp and the line length are captured in the clock cycle of the frame-start strobe, so every copy in the line agrees. Pixel codes arrive on a valid/ready stream and leave on a byte-wide valid/ready stream. A marker output separates embedded bytes from pixel bytes, and a second flag marks the final byte of the frame. Packet framing, checksums and lane distribution are left to the stage downstream.

Top module: `evpk_top`

## Requirements
- R1: While reset is asserted and after its release, out_valid_o and pix_ready_o are low until a frame starts. The first frame after reset carries frame number 0.
- R2: Embedded byte 0 is 16, byte 1 is 1, and bytes 10 to 15 are 0.
- R3: Embedded bytes 2 to 5 hold the frame number, least significant byte first, zero-extended from CNT_W bits. The number rises by one per frame and wraps from all ones to 0.
- R4: Embedded bytes 6 to 9 hold, least significant byte first, the ts_i value present in the cycle of the accepted strobe. Later changes of ts_i have no effect on that frame.
- R5: Embedded bytes 16 up to L-1 carry timestamp byte (i mod 4) at index i. L is emb_len_i sampled with the strobe, and a value below 16 is treated as 16.
- R6: Pixel k of a frame sits in bits [2(k mod 4)+1 : 2(k mod 4)] of pixel byte k/4, so the first pixel is in bits [1:0].
- R7: A final pixel byte holding fewer than four pixels has its unused bits at 0. out_last_o is high on the final byte of the frame and on no other byte.
- R8: out_embed_o is high for exactly the L embedded bytes and low for every pixel byte.
- R9: While out_valid_o is high and out_ready_i is low, the next cycle shows the same valid, data, out_embed_o and out_last_o. No byte is lost or repeated.
- R10: A strobe that arrives while a frame is still being sent is ignored. The frame does not restart and the frame number is not advanced.
- R11: pix_ready_o is low during the embedded line, so pixels are taken only after the line is finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Frame-start strobe, taken when idle |
| ts_i | input | 32 | Free-running timestamp |
| emb_len_i | input | LEN_W | Embedded line length in bytes |
| pix_valid_i | input | 1 | Pixel code valid |
| pix_code_i | input | 2 | 2-bit event code of one pixel |
| pix_last_i | input | 1 | Marks the last pixel of the frame |
| pix_ready_o | output | 1 | Pixel code accepted this cycle when high with valid |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the byte |
| out_data_o | output | 8 | Output byte |
| out_embed_o | output | 1 | Byte belongs to the embedded line |
| out_last_o | output | 1 | Final byte of the frame |

## Verification
If the frame counter or the latched timestamp goes wrong, the fault shows in header bytes 2 to 9 of the next embedded line. That is at most one frame after it happens. A wrong byte index shifts the body pattern or places the marker edge at the wrong byte within the same line. A packer slot that is out of step moves codes between bit pairs, or drops padding, in the very next pixel byte. A phase that is stuck leaves out_last_o missing, which stalls the frame until the per-frame cycle limit runs out.

// File: rtl/evpk_pkg.sv
package evpk_pkg;
  localparam int HDR_BYTES = 16;
  localparam logic [7:0] HDR_SIZE_VAL = 8'd16;
  localparam logic [7:0] HDR_TYPE_VAL = 8'd1;
  localparam int PIX_BITS = 2;
  localparam int PIX_PER_BYTE = 8 / PIX_BITS;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EMB  = 2'd1,
    PH_PIX  = 2'd2
  } phase_e;
endpackage

// File: rtl/evpk_hdr_byte.sv
module evpk_hdr_byte #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 10
) (
  input  logic [LEN_W-1:0] idx_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [31:0]      ts_i,
  output logic [7:0]       byte_o
);
  import evpk_pkg::*;

  logic [31:0] cnt32;
  assign cnt32 = 32'(cnt_i);

  always_comb begin
    byte_o = 8'd0;
    if (idx_i < LEN_W'(HDR_BYTES)) begin
      case (idx_i[3:0])
        4'd0:    byte_o = HDR_SIZE_VAL;
        4'd1:    byte_o = HDR_TYPE_VAL;
        4'd2:    byte_o = cnt32[7:0];
        4'd3:    byte_o = cnt32[15:8];
        4'd4:    byte_o = cnt32[23:16];
        4'd5:    byte_o = cnt32[31:24];
        4'd6:    byte_o = ts_i[7:0];
        4'd7:    byte_o = ts_i[15:8];
        4'd8:    byte_o = ts_i[23:16];
        4'd9:    byte_o = ts_i[31:24];
        default: byte_o = 8'd0;
      endcase
    end else begin
      byte_o = ts_i[8*idx_i[1:0] +: 8];
    end
  end
endmodule

// File: rtl/evpk_ctl.sv
module evpk_ctl #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_i,
  input  logic [31:0]        ts_i,
  input  logic [LEN_W-1:0]   emb_len_i,
  input  logic               out_fire_i,
  input  logic               frame_end_i,
  output evpk_pkg::phase_e   phase_o,
  output logic [LEN_W-1:0]   idx_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [31:0]        ts_o
);
  import evpk_pkg::*;

  phase_e            ph_q, ph_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [31:0]       ts_q;
  logic              start, emb_done, ts_en, len_en, idx_en, cnt_en;

  assign start    = (ph_q == PH_IDLE) && sof_i;
  assign emb_done = (ph_q == PH_EMB) && out_fire_i && (idx_q == len_q - LEN_W'(1));

  always_comb begin
    ph_d   = ph_q;
    idx_d  = idx_q;
    len_d  = len_q;
    cnt_d  = cnt_q;
    ts_en  = 1'b0;
    len_en = 1'b0;
    idx_en = 1'b0;
    cnt_en = 1'b0;
    case (ph_q)
      PH_IDLE: if (sof_i) begin
        ph_d   = PH_EMB;
        idx_d  = '0;
        idx_en = 1'b1;
        len_d  = (emb_len_i < LEN_W'(HDR_BYTES)) ? LEN_W'(HDR_BYTES) : emb_len_i;
        len_en = 1'b1;
        ts_en  = 1'b1;
      end
      PH_EMB: if (out_fire_i) begin
        idx_en = 1'b1;
        if (emb_done) begin
          ph_d   = PH_PIX;
          cnt_d  = cnt_q + CNT_W'(1);
          cnt_en = 1'b1;
        end else begin
          idx_d = idx_q + LEN_W'(1);
        end
      end
      PH_PIX: if (frame_end_i) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
      len_q <= LEN_W'(HDR_BYTES);
      cnt_q <= '0;
      ts_q  <= '0;
    end else begin
      ph_q <= ph_d;
      if (idx_en) idx_q <= idx_d;
      if (len_en) len_q <= len_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (ts_en)  ts_q  <= ts_i;
    end
  end

  assign phase_o = ph_q;
  assign idx_o   = idx_q;
  assign cnt_o   = cnt_q;
  assign ts_o    = ts_q;
  wire unused_start = start;
endmodule

// File: rtl/evpk_pack.sv
module evpk_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       pix_valid_i,
  input  logic [1:0] pix_code_i,
  input  logic       pix_last_i,
  input  logic       take_i,
  output logic       pix_ready_o,
  output logic       full_o,
  output logic [7:0] byte_o,
  output logic       last_o
);
  import evpk_pkg::*;
  localparam int SLOT_W = $clog2(PIX_PER_BYTE);

  logic [7:0]        acc_q, acc_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              full_q, full_d, last_q, last_d;
  logic              accept;

  assign pix_ready_o = en_i && !full_q;
  assign accept      = pix_valid_i && pix_ready_o;

  always_comb begin
    acc_d  = acc_q;
    slot_d = slot_q;
    full_d = full_q;
    last_d = last_q;
    if (take_i) begin
      acc_d  = '0;
      full_d = 1'b0;
      last_d = 1'b0;
    end else if (accept) begin
      acc_d[PIX_BITS*slot_q +: PIX_BITS] = pix_code_i;
      if (pix_last_i || (slot_q == SLOT_W'(PIX_PER_BYTE - 1))) begin
        full_d = 1'b1;
        last_d = pix_last_i;
        slot_d = '0;
      end else begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      slot_q <= '0;
      full_q <= 1'b0;
      last_q <= 1'b0;
    end else if (take_i || accept) begin
      acc_q  <= acc_d;
      slot_q <= slot_d;
      full_q <= full_d;
      last_q <= last_d;
    end
  end

  assign full_o = full_q;
  assign byte_o = acc_q;
  assign last_o = last_q;
endmodule

// File: rtl/evpk_top.sv
module evpk_top #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_i,
  input  logic [31:0]      ts_i,
  input  logic [LEN_W-1:0] emb_len_i,
  input  logic             pix_valid_i,
  input  logic [1:0]       pix_code_i,
  input  logic             pix_last_i,
  output logic             pix_ready_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic             out_embed_o,
  output logic             out_last_o
);
  import evpk_pkg::*;

  phase_e            phase;
  logic [LEN_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt;
  logic [31:0]       ts_lat;
  logic [7:0]        hdr_byte, pix_byte;
  logic              full, pix_last_byte, in_emb, in_pix, fire, pix_take;

  assign in_emb   = (phase == PH_EMB);
  assign in_pix   = (phase == PH_PIX);
  assign fire     = out_valid_o && out_ready_i;
  assign pix_take = fire && in_pix;

  evpk_ctl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof_i      (sof_i),
    .ts_i       (ts_i),
    .emb_len_i  (emb_len_i),
    .out_fire_i (fire),
    .frame_end_i(pix_take && pix_last_byte),
    .phase_o    (phase),
    .idx_o      (idx),
    .cnt_o      (cnt),
    .ts_o       (ts_lat)
  );

  evpk_hdr_byte #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_hdr (
    .idx_i (idx),
    .cnt_i (cnt),
    .ts_i  (ts_lat),
    .byte_o(hdr_byte)
  );

  evpk_pack u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (in_pix),
    .pix_valid_i(pix_valid_i),
    .pix_code_i (pix_code_i),
    .pix_last_i (pix_last_i),
    .take_i     (pix_take),
    .pix_ready_o(pix_ready_o),
    .full_o     (full),
    .byte_o     (pix_byte),
    .last_o     (pix_last_byte)
  );

  assign out_valid_o = in_emb || (in_pix && full);
  assign out_data_o  = in_emb ? hdr_byte : pix_byte;
  assign out_embed_o = in_emb;
  assign out_last_o  = in_pix && full && pix_last_byte;
endmodule

// File: rtl/evpk_chk.sv
module evpk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_ready_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       out_embed_o,
  input logic       out_last_o
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
      && $stable(out_embed_o) && $stable(out_last_o)))
    else $error("R9 output changed while stalled");

  p_no_pix_in_emb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_embed_o |-> !pix_ready_o)
    else $error("R11 pixel ready during embedded line");

  p_marker_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_embed_o |-> out_valid_o)
    else $error("R8 marker without valid byte");

  p_last_pixel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> (out_valid_o && !out_embed_o))
    else $error("R7 last flag outside pixel bytes");

  p_first_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_embed_o) |-> (out_data_o == 8'd16))
    else $error("R2 line does not open with size byte");

  p_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last_o && out_ready_i) |=> !out_valid_o)
    else $error("R10 output continues after frame end");
endmodule

bind evpk_top evpk_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_ready_o(pix_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o),
  .out_embed_o(out_embed_o),
  .out_last_o (out_last_o)
);

// File: tb/evpk_top_test.sv
module evpk_top_test;
  localparam int CW = 3;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic sof;
  logic [31:0] ts;
  logic [LW-1:0] elen;
  logic pv, plast, pready;
  logic [1:0] pcode;
  logic ov, ordy, oemb, olast;
  logic [7:0] odata;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  evpk_top #(.CNT_W(CW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .ts_i(ts), .emb_len_i(elen),
    .pix_valid_i(pv), .pix_code_i(pcode), .pix_last_i(plast),
    .pix_ready_o(pready), .out_valid_o(ov), .out_ready_i(ordy),
    .out_data_o(odata), .out_embed_o(oemb), .out_last_o(olast)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(input int f, input int p);
    return 2'((f * 3 + p * 5 + p / 3) % 4);
  endfunction

  task automatic run_frame(input int f, input bit mid_sof);
    int len, eff, npix, total, pi, oi, cyc;
    logic [31:0] tsv, cntv;
    bit emb_bad;
    len  = (f == 7) ? 5 : 16 + (f * 5) % 11;
    eff  = (len < 16) ? 16 : len;
    npix = 1 + (f * 7) % 13;
    total = eff + (npix + 3) / 4;
    tsv  = 32'hA5000000 + 32'(f) * 32'h01030507;
    cntv = 32'(f % 8);
    pi = 0; oi = 0; cyc = 0; emb_bad = 0;
    @(negedge clk);
    sof = 1'b1; ts = tsv; elen = LW'(len); ordy = 1'b0; pv = 1'b0;
    @(negedge clk);
    sof = 1'b0; ts = ~tsv;
    while (oi < total && cyc < 2000) begin
      ordy  = (cyc % 4) != 1;
      pv    = (pi < npix) && ((cyc % 3) != 2);
      pcode = code_of(f, pi);
      plast = (pi == npix - 1);
      sof   = mid_sof && (oi == eff);
      ts    = ts + 32'd1;
      #1;
      if (oemb && pready) emb_bad = 1;
      if (ov && ordy) begin
        logic [7:0] e;
        string tag;
        if (oi < 16) begin
          case (oi)
            0: begin e = 8'd16; tag = "R2 size"; end
            1: begin e = 8'd1;  tag = "R2 type"; end
            2, 3, 4, 5: begin e = cntv[8*(oi-2) +: 8]; tag = "R3 counter"; end
            6, 7, 8, 9: begin e = tsv[8*(oi-6) +: 8]; tag = "R4 timestamp"; end
            default: begin e = 8'd0; tag = "R2 zero"; end
          endcase
        end else if (oi < eff) begin
          e = tsv[8*(oi % 4) +: 8]; tag = "R5 body";
        end else begin
          e = 8'd0;
          for (int k = 0; k < 4; k++)
            if ((oi - eff) * 4 + k < npix) e[2*k +: 2] = code_of(f, (oi - eff) * 4 + k);
          tag = (oi == total - 1 && npix % 4 != 0) ? "R7 padded" : "R6 packed";
        end
        check($sformatf("%s f%0d b%0d", tag, f, oi), odata, e);
        check($sformatf("R8 marker f%0d b%0d", f, oi), oemb, oi < eff);
        check($sformatf("R7 last f%0d b%0d", f, oi), olast, oi == total - 1);
        oi++;
      end
      if (pv && pready) pi++;
      cyc++;
      @(negedge clk);
    end
    sof = 1'b0; pv = 1'b0; plast = 1'b0; ordy = 1'b1;
    check($sformatf("R11 no early pixel f%0d", f), emb_bad, 0);
    check($sformatf("watchdog f%0d", f), cyc < 2000, 1);
    repeat (2) @(negedge clk);
    check($sformatf("R10 idle after frame f%0d", f), ov, 0);
  endtask

  initial begin
    rst_n = 1'b0; sof = 1'b0; ts = '0; elen = '0;
    pv = 1'b0; pcode = '0; plast = 1'b0; ordy = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", ov, 0);
    check("R1 reset pix ready", pready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle valid", ov, 0);
    check("R1 idle pix ready", pready, 0);
    for (int f = 0; f < 12; f++) run_frame(f, f == 4);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule